// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block sits in front of a parallel memory array. It produces the word addresses for a clocked burst read. A one-cycle address strobe captures a start address and a configuration word. From that edge on, the block waits a programmable first-access latency. It then issues one word address per beat, with the beats spaced by a per-word latency of one or two cycles.

The addresses are ordered by the configured burst length and wrap order. Bursts of 4 or 8 words wrap inside their aligned group, in either sequential or XOR-interleaved order. A continuous burst counts linearly until chip enable falls. A beat-valid strobe marks each issued address. A ready flag is active only in burst mode, and it can be shifted one cycle ahead of the beats.

A single-read mode returns only the first word, as used for status and identification accesses. A separate configuration bit moves every output to the falling clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: The length field `cfg_i[2:0]` selects the group. 3'b010 is an 8-word group and 3'b111 is continuous. 3'b001 and every reserved code behave as a 4-word group.
- R2: Sequential order (`cfg_i[3]`=0) in a 4-word group adds the beat index to the start offset modulo 4. Start 1 gives 1,2,3,0 and start 3 gives 3,0,1,2. The address bits above bit 1 keep their start value.
- R3: Interleaved order (`cfg_i[3]`=1) XORs the start offset with the beat index. A 4-word start of 1 gives 1,0,3,2. An 8-word start of 5 gives 5,4,7,6,1,0,3,2.
- R4: Sequential order in an 8-word group wraps modulo 8 inside the aligned group. Start 6 gives 6,7,0,1,2,3,4,5.
- R5: The first beat is valid X edges after the latching edge, where X is `cfg_i[7:4]` and a value of 0 acts as 1. Later beats come every Y edges, with Y=2 when `cfg_i[8]`=1 and Y=1 otherwise. With Y=2 the cycle between two beats has `beat_valid_o` low.
- R6: With `cfg_i[10]`=1 all outputs are launched on the falling clock edge. They then lag the rising-edge timing by half a cycle.
- R7: `ready_o` is low unless the mode field `cfg_i[12:11]` is 2'b10 (burst). In burst mode with `cfg_i[9]`=0 it equals the beat strobe. With `cfg_i[9]`=1 it is high in the cycle before each valid beat.
- R8: Mode 2'b01 (single) gives exactly one valid beat, at the start address, after the X latency.
- R9: A continuous burst adds the beat index to the full start address, so it runs past group boundaries.
- R10: While `ce_i` is low, no burst starts, and any running burst stops at the next rising edge.
- R11: A new address strobe during a burst aborts the burst and restarts the X latency from the new address.
- R12: Modes 2'b00 and 2'b11 are asynchronous. A strobe in these modes starts no beats and aborts any burst that is running.
- R13: After reset `addr_o`, `beat_valid_o` and `ready_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable; low ends any burst |
| adv_i | input | 1 | Address strobe; latches address and configuration |
| addr_i | input | ADDR_W | Start word address |
| cfg_i | input | 13 | Configuration word (fields as in the requirements) |
| addr_o | output | ADDR_W | Word address of the current beat |
| beat_valid_o | output | 1 | High in cycles that carry a valid beat |
| ready_o | output | 1 | Ready flag for burst mode, high when data is valid (or about to be) |

## Verification
The checker assumes that the configuration seen by the sequencer changes only on an accepted address strobe. It also assumes `ce_i` is sampled cleanly at the rising edge. The gap, single-beat and group properties are therefore qualified by the latched rising-edge launch setting.

The bench changes `adv_i`, `addr_i`, `cfg_i` and `ce_i` only one nanosecond after a rising edge. It pulses the strobe for exactly one edge, and it lowers chip enable only while rising-edge launch is selected. Its reference model counts edges from the latching edge. For falling-edge launch it shifts that count by one edge to match the half-cycle lag seen at the sampling point.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int LAT_W = 4;

  typedef enum logic [1:0] {
    RM_ASYNC  = 2'b00,
    RM_SINGLE = 2'b01,
    RM_BURST  = 2'b10,
    RM_ASYNC2 = 2'b11
  } rmode_e;

  typedef struct packed {
    rmode_e            rmode;  // [12:11]
    logic              fall;   // [10]
    logic              early;  // [9]
    logic              y2;     // [8]
    logic [LAT_W-1:0]  lat_x;  // [7:4]
    logic              il;     // [3]
    logic [2:0]        blen;   // [2:0]
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {GRP_4, GRP_8, GRP_LIN} grp_e;

  function automatic grp_e len_decode(logic [2:0] code);
    case (code)
      3'b010:  return GRP_8;
      3'b111:  return GRP_LIN;
      default: return GRP_4;
    endcase
  endfunction
endpackage

// File: rtl/bas_order.sv
module bas_order
  import bas_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  grp_e              grp_i,
  input  logic              il_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] grp_addr [2];

  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam int GW = 2 + g;
    logic [GW-1:0] off;
    assign off = il_i ? (base_i[GW-1:0] ^ idx_i[GW-1:0])
                      : (base_i[GW-1:0] + idx_i[GW-1:0]);
    assign grp_addr[g] = {base_i[ADDR_W-1:GW], off};
  end

  always_comb begin
    case (grp_i)
      GRP_8:   addr_o = grp_addr[1];
      GRP_LIN: addr_o = base_i + idx_i;
      default: addr_o = grp_addr[0];
    endcase
  end
endmodule

// File: rtl/bas_pacer.sv
module bas_pacer #(
  parameter int LAT_W = 4,
  parameter int IDX_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             abort_i,
  input  logic [LAT_W-1:0] wait_i,
  input  logic             y2_i,
  input  logic             lin_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             fire_o,
  output logic             due_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             active_q;
  logic [LAT_W-1:0] wait_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wait_q   <= '0;
      idx_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      wait_q   <= wait_i;
      idx_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (wait_q == '0) begin
        if (!lin_i && idx_q == last_i) begin
          active_q <= 1'b0;
        end else begin
          idx_q  <= idx_q + 1'b1;
          wait_q <= y2_i ? LAT_W'(1) : '0;
        end
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign due_o  = active_q && (wait_q == '0);
  assign fire_o = due_o && !load_i && !abort_i;
  assign idx_o  = idx_q;
endmodule

// File: rtl/bas_launch.sv
module bas_launch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= d_i;
  end

  assign q_o = fall_i ? neg_q : d_i;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ce_i,
  input  logic                      adv_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [bas_pkg::CFG_W-1:0] cfg_i,
  output logic [ADDR_W-1:0]         addr_o,
  output logic                      beat_valid_o,
  output logic                      ready_o
);
  localparam int IDX_W = ADDR_W;
  localparam int OUT_W = ADDR_W + 2;

  cfg_t cfg_in;
  assign cfg_in = cfg_t'(cfg_i);

  logic sync_in, load, abort;
  assign sync_in = (cfg_in.rmode == RM_SINGLE) || (cfg_in.rmode == RM_BURST);
  assign load    = adv_i && ce_i && sync_in;
  assign abort   = !ce_i || (adv_i && !sync_in);

  logic [ADDR_W-1:0] base_q;
  rmode_e            rmode_q;
  logic              fall_q, early_q, y2_q, il_q;
  logic [2:0]        blen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      rmode_q <= RM_ASYNC;
      fall_q  <= 1'b0;
      early_q <= 1'b0;
      y2_q    <= 1'b0;
      il_q    <= 1'b0;
      blen_q  <= 3'b001;
    end else if (load) begin
      base_q  <= addr_i;
      rmode_q <= cfg_in.rmode;
      fall_q  <= cfg_in.fall;
      early_q <= cfg_in.early;
      y2_q    <= cfg_in.y2;
      il_q    <= cfg_in.il;
      blen_q  <= cfg_in.blen;
    end
  end

  logic [LAT_W-1:0] wait_ld;
  assign wait_ld = (cfg_in.lat_x == '0) ? '0 : cfg_in.lat_x - 1'b1;

  grp_e grp;
  logic lin, is_burst;
  logic [IDX_W-1:0] last_idx;
  assign grp      = len_decode(blen_q);
  assign is_burst = (rmode_q == RM_BURST);
  assign lin      = is_burst && (grp == GRP_LIN);
  always_comb begin
    if (!is_burst)          last_idx = '0;
    else if (grp == GRP_8)  last_idx = IDX_W'(7);
    else                    last_idx = IDX_W'(3);
  end

  logic             fire, due;
  logic [IDX_W-1:0] idx;

  bas_pacer #(.LAT_W(LAT_W), .IDX_W(IDX_W)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .abort_i (abort),
    .wait_i  (wait_ld),
    .y2_i    (y2_q),
    .lin_i   (lin),
    .last_i  (last_idx),
    .fire_o  (fire),
    .due_o   (due),
    .idx_o   (idx)
  );

  logic [ADDR_W-1:0] gen_addr;

  bas_order #(.ADDR_W(ADDR_W)) u_order (
    .base_i (base_q),
    .idx_i  (idx),
    .grp_i  (grp),
    .il_i   (il_q),
    .addr_o (gen_addr)
  );

  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) addr_q <= gen_addr;
    end
  end

  // early ready predicts the next edge's beat from the pacer state
  logic rdy_pre;
  assign rdy_pre = is_burst && (early_q ? due : valid_q);

  logic [OUT_W-1:0] launch_q;

  bas_launch #(.W(OUT_W)) u_launch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall_q),
    .d_i    ({addr_q, valid_q, rdy_pre}),
    .q_o    (launch_q)
  );

  assign addr_o       = launch_q[OUT_W-1:2];
  assign beat_valid_o = launch_q[1];
  assign ready_o      = launch_q[0];
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import bas_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              beat_valid_o,
  input logic              ready_o,
  input logic [ADDR_W-1:0] base_q,
  input rmode_e            rmode_q,
  input logic              fall_q,
  input logic              y2_q,
  input logic [2:0]        blen_q
);
  a_r5_y2_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_q && y2_q && beat_valid_o) |=> !beat_valid_o)
    else $error("a_r5_y2_gap");

  a_r8_single_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_q && rmode_q == RM_SINGLE && beat_valid_o) |=> !beat_valid_o)
    else $error("a_r8_single_one");

  a_r10_ce_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !beat_valid_o)
    else $error("a_r10_ce_stop");

  a_r7_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmode_q != RM_BURST) |-> !ready_o)
    else $error("a_r7_ready_quiet");

  // R2 R4: grouped bursts never leave the aligned 8-word block of the start
  a_r4_group_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_q && beat_valid_o && blen_q != 3'b111)
      |-> addr_o[ADDR_W-1:3] == base_q[ADDR_W-1:3])
    else $error("a_r4_group_kept");
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_i         (ce_i),
  .addr_o       (addr_o),
  .beat_valid_o (beat_valid_o),
  .ready_o      (ready_o),
  .base_q       (base_q),
  .rmode_q      (rmode_q),
  .fall_q       (fall_q),
  .y2_q         (y2_q),
  .blen_q       (blen_q)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 21;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_i = 1'b0;
  logic          adv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [12:0]   cfg_i = '0;
  logic [AW-1:0] addr_o;
  logic          beat_valid_o;
  logic          ready_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .adv_i(adv_i),
    .addr_i(addr_i), .cfg_i(cfg_i),
    .addr_o(addr_o), .beat_valid_o(beat_valid_o), .ready_o(ready_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] mk_cfg(input logic [1:0] mode, input bit fall, input bit early,
                                         input bit y2, input int x, input bit il, input logic [2:0] bl);
    return {mode, fall, early, y2, 4'(x), il, bl};
  endfunction

  function automatic bit exp_valid(input int d, input int x, input int y, input int n);
    int xe;
    xe = (x == 0) ? 1 : x;
    if (d < xe) return 1'b0;
    if (((d - xe) % y) != 0) return 1'b0;
    if (((d - xe) / y) >= n) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k,
                                             input logic [2:0] bl, input bit il);
    logic [AW-1:0] kk;
    kk = AW'(k);
    if (bl == 3'b111) return b + kk;
    if (bl == 3'b010) return {b[AW-1:3], il ? (b[2:0] ^ kk[2:0]) : (b[2:0] + kk[2:0])};
    return {b[AW-1:2], il ? (b[1:0] ^ kk[1:0]) : (b[1:0] + kk[1:0])};
  endfunction

  // latch one burst, then compare ncyc cycles; drop>0 lowers ce after that cycle
  task automatic do_burst(input string req, input logic [AW-1:0] base,
                          input logic [12:0] cfg, input int ncyc, input int drop);
    int x, y, n, eff, xe;
    bit fall, early, burst, ev, evn, er;
    x     = int'(cfg[7:4]);
    xe    = (x == 0) ? 1 : x;
    y     = cfg[8] ? 2 : 1;
    fall  = cfg[10];
    early = cfg[9];
    burst = (cfg[12:11] == 2'b10);
    if (cfg[12:11] == 2'b01)      n = 1;
    else if (!burst)              n = 0;
    else if (cfg[2:0] == 3'b111)  n = 1 << 30;
    else if (cfg[2:0] == 3'b010)  n = 8;
    else                          n = 4;
    addr_i = base; cfg_i = cfg; adv_i = 1'b1; ce_i = 1'b1;
    @(posedge clk_i); #1;
    adv_i = 1'b0;
    for (int d = 1; d <= ncyc; d++) begin
      @(posedge clk_i); #1;
      eff = fall ? d - 1 : d;
      ev  = (drop > 0 && eff > drop) ? 1'b0 : exp_valid(eff, x, y, n);
      evn = (drop > 0 && eff + 1 > drop) ? 1'b0 : exp_valid(eff + 1, x, y, n);
      er  = burst ? (early ? evn : ev) : 1'b0;
      chk(req, $sformatf("valid d=%0d", d), longint'(beat_valid_o), longint'(ev));
      chk(req, $sformatf("ready d=%0d", d), longint'(ready_o), longint'(er));
      if (ev)
        chk(req, $sformatf("addr d=%0d", d), longint'(addr_o),
            longint'(exp_addr(base, (eff - xe) / y, cfg[2:0], cfg[3])));
      if (d == drop) ce_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R13", "addr", longint'(addr_o), 0);
    chk("R13", "valid", longint'(beat_valid_o), 0);
    chk("R13", "ready", longint'(ready_o), 0);
  endtask

  task automatic t_seq4();
    do_burst("R2", 21'h01001, mk_cfg(2'b10, 0, 0, 0, 3, 0, 3'b001), 10, 0);
    do_burst("R2", 21'h02003, mk_cfg(2'b10, 0, 0, 0, 2, 0, 3'b001), 8, 0);
  endtask

  task automatic t_inter();
    do_burst("R3", 21'h00005, mk_cfg(2'b10, 0, 0, 0, 2, 1, 3'b001), 8, 0);
    do_burst("R3", 21'h00015, mk_cfg(2'b10, 0, 0, 0, 3, 1, 3'b010), 14, 0);
  endtask

  task automatic t_seq8_y2();
    do_burst("R4", 21'h00106, mk_cfg(2'b10, 0, 0, 1, 4, 0, 3'b010), 24, 0);
  endtask

  task automatic t_lat();
    do_burst("R5", 21'h00000, mk_cfg(2'b10, 0, 0, 0, 0, 0, 3'b001), 7, 0);
    do_burst("R5", 21'h00a02, mk_cfg(2'b10, 0, 0, 1, 7, 0, 3'b001), 18, 0);
  endtask

  task automatic t_fall();
    do_burst("R6", 21'h00032, mk_cfg(2'b10, 1, 0, 0, 2, 0, 3'b001), 9, 0);
    do_burst("R6", 21'h00047, mk_cfg(2'b10, 1, 1, 1, 3, 1, 3'b010), 22, 0);
  endtask

  task automatic t_ready();
    do_burst("R7", 21'h00201, mk_cfg(2'b10, 0, 1, 1, 3, 0, 3'b001), 14, 0);
    do_burst("R7", 21'h00203, mk_cfg(2'b10, 0, 1, 0, 1, 0, 3'b001), 7, 0);
  endtask

  task automatic t_single();
    do_burst("R8", 21'h1abcd, mk_cfg(2'b01, 0, 1, 0, 3, 0, 3'b111), 9, 0);
  endtask

  task automatic t_cont();
    do_burst("R10", 21'h000fe, mk_cfg(2'b10, 0, 0, 0, 2, 0, 3'b111), 12, 8);
    chk("R9", "addr held after stop", longint'(addr_o), longint'(21'h00104));
  endtask

  task automatic t_restart();
    do_burst("R11", 21'h00300, mk_cfg(2'b10, 0, 0, 0, 2, 0, 3'b111), 4, 0);
    do_burst("R11", 21'h00402, mk_cfg(2'b10, 0, 0, 0, 3, 0, 3'b001), 9, 0);
  endtask

  task automatic t_async();
    do_burst("R12", 21'h00500, mk_cfg(2'b10, 0, 0, 0, 1, 0, 3'b111), 4, 0);
    do_burst("R12", 21'h00600, mk_cfg(2'b00, 0, 0, 0, 1, 0, 3'b001), 6, 0);
    do_burst("R12", 21'h00700, mk_cfg(2'b11, 0, 0, 0, 2, 0, 3'b001), 6, 0);
  endtask

  task automatic t_len();
    do_burst("R1", 21'h00811, mk_cfg(2'b10, 0, 0, 0, 2, 0, 3'b011), 9, 0);
    do_burst("R1", 21'h00817, mk_cfg(2'b10, 0, 0, 0, 2, 0, 3'b000), 9, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_seq4();
    t_inter();
    t_seq8_y2();
    t_lat();
    t_fall();
    t_ready();
    t_single();
    t_cont();
    t_restart();
    t_async();
    t_len();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule